// File: doc/BRIEF.md
# Lane-Configurable SIMD Integer ALU

This block is a 64-bit integer arithmetic unit that treats every operand as a packed vector of equal-width lanes. A shared 32-bit configuration word holds a 2-bit lane-size code for each of sixteen registers. The destination register's code sets the lane width of an operation. Add, subtract, shift left and shift right then run independently in every lane, and no bit passes from one lane into the next.

The two source registers may carry a lane width that differs from the destination's. When a source has fewer, wider elements, they are repeated cyclically across the destination lanes and each element is cut down to the destination width. When a source has more, narrower elements, destination lane i takes element i and widens it. Optional modes give a per-lane carry or borrow chain, a per-lane overflow report, and signed or unsigned interpretation. The logic between the inputs and the outputs is combinational, and the result is captured in one output register.

Top module: `simd_lane_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `result`, `carry_out` and `ovf_out` are all zero.
- R2: `out_valid` goes high one clock after `in_valid` is sampled high. Whenever `in_valid` is low, `result`, `carry_out` and `ovf_out` keep their previous values.
- R3: The lane width is taken from `lane_cfg[2*rd_idx+1 : 2*rd_idx]`, with 00=8, 01=16, 10=32 and 11=64 bits. With `op_sel`=00, each lane computes a+b modulo 2^width, and no carry passes into the next lane.
- R4: With `op_sel`=01, each lane computes a-b modulo 2^width, independently of the other lanes.
- R5: When a source's lane width (taken from its own index field) is wider than the destination lane, destination lane i uses source element (i mod source lane count), and only its low destination-width bits are kept. A single 64-bit element therefore reaches every lane.
- R6: When a source's lane width is narrower than the destination lane, destination lane i uses source element i. That element is zero-extended when `signed_mode`=0 and sign-extended when `signed_mode`=1.
- R7: When `carry_mode`=1, an add or subtract in lane i also adds or subtracts `carry_in[i]`, and `carry_out[i]` reports that lane's carry or borrow out. When `carry_mode`=0, `carry_in` has no effect and `carry_out` is zero.
- R8: When `ovf_mode`=1 and the operation is an add or subtract, `ovf_out[i]` reports signed overflow of lane i if `signed_mode`=1, and unsigned carry or borrow out if `signed_mode`=0. When `ovf_mode`=0, `ovf_out` is zero.
- R9: With `op_sel`=10 each lane shifts left and with `op_sel`=11 each lane shifts right. The shift amount is the second operand's lane value modulo the lane width. A right shift is arithmetic when `signed_mode`=1 and logical otherwise. A shift reports zero carry and zero overflow.
- R10: Bits of `carry_out` and `ovf_out` at or above the destination lane count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operation strobe |
| src_a | input | 64 | First operand value |
| src_b | input | 64 | Second operand value or shift amounts |
| ra_idx | input | 4 | Register index of the first operand |
| rb_idx | input | 4 | Register index of the second operand |
| rd_idx | input | 4 | Register index of the destination |
| lane_cfg | input | 32 | Lane-size codes, 2 bits per register |
| op_sel | input | 2 | 00 add, 01 subtract, 10 shift left, 11 shift right |
| carry_mode | input | 1 | Enable per-lane carry/borrow in and out |
| ovf_mode | input | 1 | Enable per-lane overflow report |
| signed_mode | input | 1 | Signed lane interpretation |
| carry_in | input | 8 | Per-lane carry or borrow in |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Packed lane results |
| carry_out | output | 8 | Per-lane carry or borrow out |
| ovf_out | output | 8 | Per-lane overflow flags |

## Verification
The hardest case to reach is one where the three register indices select three different lane widths at once, with the carry-in bits and the extreme lane values landing exactly on the destination lane boundaries. Uniform random configuration words rarely produce a wide source, a narrow source and a carry chain in the same cycle together with a sign bit set in the element being extended. The stimulus therefore starts with directed configuration words that pin each of the three indexed fields to a chosen width, using lane values such as 0x7F, 0x80 and all-ones. It then runs a long random phase in which the indices, the configuration word and the mode bits all vary, compared against a lane-by-lane behavioural model on every clock.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int XLEN = 64,
  parameter int NREG = 16,
  parameter int MINW = 8,
  localparam int NLANE = XLEN / MINW,
  localparam int IDXW = $clog2(NREG),
  localparam int SHW = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [IDXW-1:0]  ra_idx,
  input  logic [IDXW-1:0]  rb_idx,
  input  logic [IDXW-1:0]  rd_idx,
  input  logic [2*NREG-1:0] lane_cfg,
  input  logic [1:0]       op_sel,
  input  logic             carry_mode,
  input  logic             ovf_mode,
  input  logic             signed_mode,
  input  logic [NLANE-1:0] carry_in,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic [NLANE-1:0] carry_out,
  output logic [NLANE-1:0] ovf_out
);

  logic [1:0] sz_a, sz_b, sz_d;
  logic [XLEN-1:0] ga, gb, res_c;
  logic [NLANE-1:0] cy_c, ov_c;

  assign sz_a = lane_cfg[{ra_idx, 1'b0} +: 2];
  assign sz_b = lane_cfg[{rb_idx, 1'b0} +: 2];
  assign sz_d = lane_cfg[{rd_idx, 1'b0} +: 2];

  function automatic logic [XLEN-1:0] spread(input logic [XLEN-1:0] v, input logic [1:0] s,
                                             input logic [1:0] d, input logic sx);
    logic [XLEN-1:0] r, e;
    int ws, wd, ns, nd;
    ws = MINW << s;
    wd = MINW << d;
    ns = NLANE >> s;
    nd = NLANE >> d;
    r = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (i < nd) begin
        e = v >> ((i % ns) * ws);
        if (ws < XLEN) e = e & ~({XLEN{1'b1}} << ws);
        if (sx && ws < wd && e[ws-1]) e = e | ({XLEN{1'b1}} << ws);
        if (wd < XLEN) e = e & ~({XLEN{1'b1}} << wd);
        r = r | (e << (i * wd));
      end
    end
    return r;
  endfunction

  assign ga = spread(src_a, sz_a, sz_d, signed_mode);
  assign gb = spread(src_b, sz_b, sz_d, signed_mode);

  always_comb begin
    logic [XLEN:0] la, lb, lr, msk;
    logic sa, sb, sr, cin;
    int wd, nd, amt;
    wd = MINW << sz_d;
    nd = NLANE >> sz_d;
    msk = ({{XLEN{1'b0}}, 1'b1} << wd) - 1'b1;
    res_c = '0;
    cy_c = '0;
    ov_c = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (i < nd) begin
        la = {1'b0, ga >> (i * wd)} & msk;
        lb = {1'b0, gb >> (i * wd)} & msk;
        cin = carry_mode & carry_in[i];
        amt = int'(lb[SHW-1:0]) & (wd - 1);
        sa = la[wd-1];
        sb = lb[wd-1];
        case (op_sel)
          2'd0: lr = la + lb + {{XLEN{1'b0}}, cin};
          2'd1: lr = la - lb - {{XLEN{1'b0}}, cin};
          2'd2: lr = (la << amt) & msk;
          default: lr = (signed_mode && sa) ? ((la >> amt) | (msk & ~(msk >> amt))) : (la >> amt);
        endcase
        sr = lr[wd-1];
        if (!op_sel[1]) begin
          if (carry_mode) cy_c[i] = lr[wd];
          if (ovf_mode)
            ov_c[i] = signed_mode ? (op_sel[0] ? (sa != sb && sr != sa) : (sa == sb && sr != sa))
                                  : lr[wd];
        end
        res_c = res_c | ((lr[XLEN-1:0] & msk[XLEN-1:0]) << (i * wd));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= '0;
      ovf_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_c;
        carry_out <= cy_c;
        ovf_out   <= ov_c;
      end
    end
  end

endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int XLEN = 64,
  parameter int NREG = 16,
  parameter int MINW = 8,
  localparam int NLANE = XLEN / MINW,
  localparam int IDXW = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [IDXW-1:0]  rd_idx,
  input logic [2*NREG-1:0] lane_cfg,
  input logic [1:0]       op_sel,
  input logic             carry_mode,
  input logic             ovf_mode,
  input logic             out_valid,
  input logic [XLEN-1:0]  result,
  input logic [NLANE-1:0] carry_out,
  input logic [NLANE-1:0] ovf_out
);

  logic [1:0] dsz;
  assign dsz = lane_cfg[{rd_idx, 1'b0} +: 2];

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry_out) && $stable(ovf_out)));

  a_r7_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !carry_mode) |=> (carry_out == '0));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ovf_mode) |=> (ovf_out == '0));

  a_r9_shift_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[1]) |=> (carry_out == '0 && ovf_out == '0));

  a_r10_unused_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((carry_out | ovf_out) >> (NLANE >> $past(dsz))) == '0));

endmodule

bind simd_lane_alu simd_lane_alu_chk #(.XLEN(XLEN), .NREG(NREG), .MINW(MINW)) u_chk (.*);

// File: tb/sim_simd_lane_alu.sv
module sim_simd_lane_alu;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [3:0] ra_idx = '0, rb_idx = '0, rd_idx = '0;
  logic [31:0] lane_cfg = '0;
  logic [1:0] op_sel = '0;
  logic carry_mode = 1'b0, ovf_mode = 1'b0, signed_mode = 1'b0;
  logic [7:0] carry_in = '0;
  logic out_valid;
  logic [63:0] result;
  logic [7:0] carry_out, ovf_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic exp_v = 1'b0;
  logic [63:0] exp_r = '0;
  logic [7:0] exp_c = '0, exp_o = '0;

  always #(PERIOD/2) clk = ~clk;

  simd_lane_alu u0 (.*);

  function automatic logic [64:0] pick(input logic [63:0] v, input int ws, input int k,
                                       input int wd, input logic sm);
    logic [64:0] e;
    int j;
    e = '0;
    j = k % (64 / ws);
    for (int t = 0; t < 64; t++)
      if (t < wd) e[t] = (t < ws) ? v[j*ws+t] : (sm & v[j*ws+ws-1]);
    return e;
  endfunction

  function automatic logic signed [67:0] sval(input logic [64:0] x, input int w);
    logic signed [67:0] t;
    t = $signed({3'b0, x});
    if (x[w-1]) t = t - (68'sd1 <<< w);
    return t;
  endfunction

  task automatic model;
    int wd, wa, wb, n, amt;
    logic [64:0] ua, ub;
    logic [66:0] u;
    logic signed [67:0] s, lim;
    logic c, cy, sov;
    wd = 8 << lane_cfg[rd_idx*2 +: 2];
    wa = 8 << lane_cfg[ra_idx*2 +: 2];
    wb = 8 << lane_cfg[rb_idx*2 +: 2];
    n = 64 / wd;
    lim = 68'sd1 <<< (wd - 1);
    exp_r = '0; exp_c = '0; exp_o = '0;
    for (int k = 0; k < n; k++) begin
      ua = pick(src_a, wa, k, wd, signed_mode);
      ub = pick(src_b, wb, k, wd, signed_mode);
      c = carry_mode & carry_in[k];
      amt = int'(ub[5:0]) % wd;
      cy = 1'b0; sov = 1'b0;
      case (op_sel)
        2'd0: begin
          u = {2'b0, ua} + {2'b0, ub} + c;
          cy = u[wd];
          s = sval(ua, wd) + sval(ub, wd) + c;
          sov = (s >= lim) || (s < -lim);
        end
        2'd1: begin
          u = {2'b0, ua} - {2'b0, ub} - c;
          cy = ({2'b0, ua} < ({2'b0, ub} + c));
          s = sval(ua, wd) - sval(ub, wd) - c;
          sov = (s >= lim) || (s < -lim);
        end
        2'd2: u = {2'b0, ua} << amt;
        default: begin
          if (signed_mode) begin
            s = sval(ua, wd) >>> amt;
            u = s[66:0];
          end else u = {2'b0, ua} >> amt;
        end
      endcase
      for (int t = 0; t < 64; t++) if (t < wd) exp_r[k*wd+t] = u[t];
      if (!op_sel[1]) begin
        if (carry_mode) exp_c[k] = cy;
        if (ovf_mode) exp_o[k] = signed_mode ? sov : cy;
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (out_valid !== exp_v) begin
      errors++; $display("FAIL %s out_valid actual %0b expected %0b", tag, out_valid, exp_v);
    end
    checks++;
    if (result !== exp_r) begin
      errors++; $display("FAIL %s result actual %h expected %h", tag, result, exp_r);
    end
    checks++;
    if (carry_out !== exp_c) begin
      errors++; $display("FAIL %s carry_out actual %b expected %b", tag, carry_out, exp_c);
    end
    checks++;
    if (ovf_out !== exp_o) begin
      errors++; $display("FAIL %s ovf_out actual %b expected %b", tag, ovf_out, exp_o);
    end
  endtask

  task automatic op(input logic [31:0] cfg, input logic [3:0] ia, ib, id, input logic [1:0] o,
                    input logic cm, om, sm, input logic [7:0] ci,
                    input logic [63:0] a, b, input string tag);
    in_valid = 1'b1; lane_cfg = cfg; ra_idx = ia; rb_idx = ib; rd_idx = id; op_sel = o;
    carry_mode = cm; ovf_mode = om; signed_mode = sm; carry_in = ci; src_a = a; src_b = b;
    model();
    exp_v = 1'b1;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    in_valid = 1'b0;
    src_a = ~src_a; src_b = ~src_b; op_sel = ~op_sel; carry_in = ~carry_in;
    exp_v = 1'b0;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // registers: 0=8b,1=16b,2=32b,3=64b, rest 8b
    op(32'h0000_00E4, 0, 0, 0, 2'd0, 0, 0, 0, 8'h00, 64'h01FF_7F80_00FF_10FF, 64'h0101_0180_0001_2001, "R3 add 8-bit lanes");
    op(32'h0000_00E4, 1, 1, 1, 2'd0, 0, 0, 0, 8'h00, 64'hFFFF_0001_8000_1234, 64'h0001_0001_8000_0001, "R3 add 16-bit lanes");
    op(32'h0000_00E4, 2, 2, 2, 2'd0, 1, 1, 0, 8'h00, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, "R3 add 32-bit lanes");
    op(32'h0000_00E4, 3, 3, 3, 2'd0, 1, 1, 0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, "R3 add 64-bit lane");
    idle("R2 hold after add");
    idle("R2 hold second idle");
    op(32'h0000_00E4, 0, 0, 0, 2'd1, 1, 1, 0, 8'h00, 64'h0000_0100_0510_FF00, 64'h0100_0001_0311_0101, "R4 sub 8-bit borrows");
    op(32'h0000_00E4, 1, 1, 1, 2'd1, 0, 1, 1, 8'h00, 64'h8000_7FFF_0000_1000, 64'h0001_FFFF_0001_0800, "R4 sub 16-bit signed");
    op(32'h0000_00E4, 2, 0, 0, 2'd0, 0, 0, 0, 8'h00, 64'h4444_4444_3333_3322, 64'h0, "R5 32-bit source on 8-bit lanes");
    op(32'h0000_00E4, 3, 0, 1, 2'd0, 0, 0, 0, 8'h00, 64'h1234_5678_9ABC_DEF0, 64'h0001_0002_0003_0004, "R5 64-bit broadcast");
    op(32'h0000_00E4, 0, 3, 2, 2'd1, 0, 0, 0, 8'h00, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0005, "R5 broadcast subtrahend");
    op(32'h0000_00E4, 0, 2, 2, 2'd0, 0, 0, 0, 8'h00, 64'hFFFF_FFFF_FFFF_7F80, 64'h0, "R6 zero-extend unsigned");
    op(32'h0000_00E4, 0, 2, 2, 2'd0, 0, 0, 1, 8'h00, 64'hFFFF_FFFF_FFFF_7F80, 64'h0, "R6 sign-extend signed");
    op(32'h0000_00E4, 1, 0, 3, 2'd0, 0, 0, 1, 8'h00, 64'h0, 64'h0000_0000_0000_00F0, "R6 16 and 8 into 64");
    op(32'h0000_00E4, 0, 0, 0, 2'd0, 1, 0, 0, 8'hA5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R7 carry in per lane");
    op(32'h0000_00E4, 0, 0, 0, 2'd0, 0, 0, 0, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R7 carry in ignored");
    op(32'h0000_00E4, 1, 1, 1, 2'd1, 1, 0, 0, 8'h05, 64'h0000_0001_0000_0005, 64'h0000_0000_0000_0005, "R7 borrow chain");
    op(32'h0000_00E4, 0, 0, 0, 2'd0, 0, 1, 1, 8'h00, 64'h7F80_7F80_0102_037F, 64'h01FF_7F80_0102_0301, "R8 signed add overflow");
    op(32'h0000_00E4, 0, 0, 0, 2'd0, 0, 1, 0, 8'h00, 64'h7F80_7F80_0102_03FF, 64'h01FF_7F80_0102_0301, "R8 unsigned add overflow");
    op(32'h0000_00E4, 2, 2, 2, 2'd1, 0, 1, 1, 8'h00, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, "R8 signed sub overflow");
    op(32'h0000_00E4, 0, 0, 0, 2'd2, 1, 1, 0, 8'hFF, 64'h8001_FF81_0F01_FF01, 64'h0109_0704_0108_0001, "R9 shift left 8-bit");
    op(32'h0000_00E4, 0, 0, 0, 2'd3, 0, 0, 0, 8'h00, 64'h8001_FF81_0F01_FF80, 64'h0109_0704_0108_0001, "R9 logical right");
    op(32'h0000_00E4, 0, 0, 0, 2'd3, 0, 0, 1, 8'h00, 64'h8001_FF81_0F01_FF80, 64'h0109_0704_0108_0001, "R9 arithmetic right");
    op(32'h0000_00E4, 3, 3, 3, 2'd3, 1, 1, 1, 8'h00, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0043, "R9 64-bit shift masked");
    op(32'h0000_00E4, 2, 2, 2, 2'd0, 1, 1, 1, 8'hFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, "R10 upper flag bits");

    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 4) == 0) idle("R2 random idle");
      else op($urandom, 4'($urandom), 4'($urandom), 4'($urandom), 2'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
              {$urandom, $urandom}, {$urandom, $urandom}, "R3 random lanes");
    end

    rst_n = 1'b0;
    exp_v = 1'b0; exp_r = '0; exp_c = '0; exp_o = '0;
    #1;
    compare("R1 mid-run reset");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule